// File: doc/BRIEF.md
# Bit Matrix Multiply Unit

This unit reads each 64-bit operand as an 8x8 matrix of single bits. It can transpose the first operand. It can also multiply the two operands over GF(2), where the products are summed by parity. A third mode forms a boolean product, where the products are summed by OR. Before either product, the second operand is transposed, so every result bit comes from one row of the first operand and one column of the second.

The unit is a one-cycle pipeline. A caller presents both operands and the operation select, and pulses `valid_i`. One clock later the registered result appears on `result_o`, and `valid_o` is high for exactly that cycle. Between strobes the output register keeps its value.

Top module: `bmm_unit`

## Requirements
- R1: Row r of an operand is byte r, bits 8r+7..8r. With `op_i` = 2'b00 the result is the transpose of `a_i`: bit k of result byte j equals bit j of `a_i` byte k, for all j, k in 0..7.
- R2: With `op_i` = 2'b01, result bit i (i = 8r + c) is the parity of (byte r of `a_i`) AND (byte c of transpose(`b_i`)).
- R3: With `op_i` = 2'b10, result bit i is 1 exactly when (byte r of `a_i`) AND (byte c of transpose(`b_i`)) is nonzero.
- R4: Both products transpose `b_i` and use `a_i` unchanged. With `a_i` equal to the identity 0x8040201008040201, both products return `b_i`. With `b_i` equal to the identity, both products return `a_i`.
- R5: `op_i` = 2'b11 is reserved and loads a result of zero.
- R6: `valid_o` is high in the cycle after a clock edge that samples `valid_i` high, and low after an edge that samples it low. The result is valid in that same cycle.
- R7: When `valid_i` is low, `result_o` keeps its value, whatever `a_i`, `b_i` and `op_i` do.
- R8: When `rst_ni` is low, `result_o` and `valid_o` are cleared at once, without waiting for a clock.
- R9: The transpose equals the 64-bit perfect shuffle with control 31 applied three times in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| op_i | input | 2 | 00 transpose, 01 XOR product, 10 OR product, 11 reserved |
| a_i | input | 64 | First matrix operand |
| b_i | input | 64 | Second matrix operand |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result valid, one cycle after the strobe |

## Verification
The two faults hardest to expose at the ports are a missing transpose of `b_i` and a confusion between parity and any-set. A symmetric `b_i`, such as all-ones, all-zeros or the identity, hides a missing transpose entirely. Parity and any-set give the same answer whenever each row-column AND has at most one bit set. The stimulus therefore pairs the identity with strongly asymmetric operands, and uses dense all-ones rows, whose ANDs have an even count of eight. In those cases the XOR and OR products must differ bit for bit.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int unsigned DIM = 8;
  localparam int unsigned WIDTH = DIM * DIM;

  typedef enum logic [1:0] {
    OP_FLIP = 2'b00,
    OP_XOR  = 2'b01,
    OP_OR   = 2'b10,
    OP_RSVD = 2'b11
  } bmm_op_e;
endpackage

// File: rtl/bmm_transpose.sv
module bmm_transpose #(
  parameter int unsigned DIM = 8,
  localparam int unsigned WIDTH = DIM * DIM
) (
  input  logic [WIDTH-1:0] m_i,
  output logic [WIDTH-1:0] t_o
);
  for (genvar j = 0; j < DIM; j++) begin : g_row
    for (genvar k = 0; k < DIM; k++) begin : g_col
      assign t_o[j*DIM + k] = m_i[k*DIM + j];
    end
  end
endmodule

// File: rtl/bmm_product.sv
module bmm_product #(
  parameter int unsigned DIM = 8,
  localparam int unsigned WIDTH = DIM * DIM
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] bt_i,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] or_o
);
  for (genvar r = 0; r < DIM; r++) begin : g_r
    for (genvar c = 0; c < DIM; c++) begin : g_c
      logic [DIM-1:0] term;
      assign term = a_i[r*DIM +: DIM] & bt_i[c*DIM +: DIM];
      assign xor_o[r*DIM + c] = ^term;
      assign or_o[r*DIM + c]  = |term;
    end
  end
endmodule

// File: rtl/bmm_unit.sv
module bmm_unit
  import bmm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             valid_o
);
  logic [WIDTH-1:0] a_flip, b_flip, prod_xor, prod_or, nxt;

  bmm_transpose #(.DIM(DIM)) u_flip_a (.m_i(a_i), .t_o(a_flip));
  bmm_transpose #(.DIM(DIM)) u_flip_b (.m_i(b_i), .t_o(b_flip));

  bmm_product #(.DIM(DIM)) u_prod (
    .a_i  (a_i),
    .bt_i (b_flip),
    .xor_o(prod_xor),
    .or_o (prod_or)
  );

  always_comb begin
    unique case (bmm_op_e'(op_i))
      OP_FLIP: nxt = a_flip;
      OP_XOR:  nxt = prod_xor;
      OP_OR:   nxt = prod_or;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end

  a_r6_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r6_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  a_r5_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b11) |=> result_o == '0);
  a_r3_or_zero_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && a_i == '0) |=> result_o == '0);
  a_r1_flip_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b00 && a_i == '1) |=> result_o == '1);
endmodule

// File: tb/sim_bmm_unit.sv
`timescale 1ns/1ps
module sim_bmm_unit;
  localparam logic [63:0] IDENT = 64'h8040201008040201;

  logic        clk = 0, rst_n = 0, vld = 0;
  logic [1:0]  op = 0;
  logic [63:0] a = 0, b = 0, res;
  logic        vout;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  bmm_unit u0 (.clk_i(clk), .rst_ni(rst_n), .valid_i(vld), .op_i(op),
               .a_i(a), .b_i(b), .result_o(res), .valid_o(vout));

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [63:0] m_flip(logic [63:0] m);
    logic [63:0] t;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 8; k++) t[8*j+k] = m[8*k+j];
    return t;
  endfunction

  function automatic logic [63:0] m_prod(logic [63:0] x, logic [63:0] y, bit use_or);
    logic [63:0] r, yt;
    yt = m_flip(y);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] t;
      t = x[8*(i/8) +: 8] & yt[8*(i%8) +: 8];
      r[i] = use_or ? (t != 0) : ^t;
    end
    return r;
  endfunction

  function automatic logic [63:0] stage(logic [63:0] s, logic [63:0] ml, logic [63:0] mr, int n);
    return (s & ~(ml | mr)) | ((s << n) & ml) | ((s >> n) & mr);
  endfunction

  function automatic logic [63:0] shfl31(logic [63:0] x);
    x = stage(x, 64'h0000ffff00000000, 64'h00000000ffff0000, 16);
    x = stage(x, 64'h00ff000000ff0000, 64'h0000ff000000ff00, 8);
    x = stage(x, 64'h0f000f000f000f00, 64'h00f000f000f000f0, 4);
    x = stage(x, 64'h3030303030303030, 64'h0c0c0c0c0c0c0c0c, 2);
    x = stage(x, 64'h4444444444444444, 64'h2222222222222222, 1);
    return x;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at following negedge (one register later)
  task automatic run(logic [1:0] o, logic [63:0] x, logic [63:0] y,
                     logic [63:0] exp, string req);
    @(negedge clk); vld = 1; op = o; a = x; b = y;
    @(negedge clk); vld = 0;
    check(req, res, exp);
    check("R6 valid high", {63'd0, vout}, 64'd1);
  endtask

  task automatic t_reset;
    check("R8 reset result", res, 64'd0);
    check("R8 reset valid", {63'd0, vout}, 64'd0);
  endtask

  task automatic t_flip;
    logic [63:0] x;
    run(2'b00, IDENT, 0, IDENT, "R1 flip identity");
    run(2'b00, '1, 0, '1, "R1 flip ones");
    run(2'b00, '0, 0, '0, "R1 flip zeros");
    run(2'b00, 64'h00000000000000ff, 0, 64'h0101010101010101, "R1 flip row0");
    for (int n = 0; n < 6; n++) begin
      x = {$urandom, $urandom};
      run(2'b00, x, 0, m_flip(x), "R1 flip random");
      check("R9 triple shuffle", res, shfl31(shfl31(shfl31(x))));
    end
  endtask

  task automatic t_products;
    logic [63:0] x, y;
    x = 64'h0123456789abcdef;
    run(2'b01, IDENT, x, x, "R4 xor ident left");
    run(2'b10, IDENT, x, x, "R4 or ident left");
    run(2'b01, x, IDENT, x, "R4 xor ident right");
    run(2'b10, x, IDENT, x, "R4 or ident right");
    run(2'b01, '1, '1, '0, "R2 xor ones parity even");
    run(2'b10, '1, '1, '1, "R3 or ones");
    run(2'b10, '0, x, '0, "R3 or zeros");
    for (int n = 0; n < 8; n++) begin
      x = {$urandom, $urandom}; y = {$urandom, $urandom};
      run(2'b01, x, y, m_prod(x, y, 0), "R2 xor random");
      run(2'b10, x, y, m_prod(x, y, 1), "R3 or random");
    end
  endtask

  task automatic t_reserved;
    run(2'b11, '1, '1, '0, "R5 reserved zero");
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    run(2'b00, 64'h00000000000000ff, 0, 64'h0101010101010101, "R7 setup");
    keep = res;
    @(negedge clk); op = 2'b01; a = '1; b = '1;
    @(negedge clk); a = 64'h5; op = 2'b11;
    check("R7 hold result", res, keep);
    check("R6 valid low", {63'd0, vout}, 64'd0);
  endtask

  task automatic t_async_reset;
    run(2'b10, '1, '1, '1, "R8 setup");
    #2 rst_n = 0; #1;
    check("R8 async result", res, 64'd0);
    check("R8 async valid", {63'd0, vout}, 64'd0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1; t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_flip();
    t_products();
    t_reserved();
    t_hold();
    t_async_reset();
    run(2'b00, IDENT, 0, IDENT, "R1 after reset");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule